// File: doc/BRIEF.md
# Power-Management Event Router

This block holds a pair of byte-wide power-management control registers on a simple I/O register bus and turns their settings into two level interrupt requests. The first line, `sci`, goes to the operating system. The second line, `smi`, goes to platform firmware. The register pair is relocatable. Its base address comes from a configuration input, and the two registers decode at base+4 and base+5.

One enable bit decides where shared power-management events go: either to `sci`, or (when firmware has opted in) to `smi`, or nowhere. A second enable lets a bus-master activity request raise `sci`. A self-clearing release strobe lets operating-system software hand an event to firmware. Writing that strobe sets a firmware status flag. The flag raises `smi` while the firmware enable input is high. Firmware clears the flag with a clear strobe input.

Top module: `pm_evt_router`

## Requirements
- R1: After reset both registers read 00h, and `sci`, `smi` and `fw_sts` are 0.
- R2: A read hits (`io_rd_hit`=1) only when `io_rd`=1 and `io_addr` equals base+4 (control 1) or base+5 (control 2). Any other access gives `io_rd_hit`=0 and `io_rdata`=00h.
- R3: Control 1 bit 0 (route-to-SCI enable) and bit 1 (bus-master reload enable) are read/write and read back what was written.
- R4: Control 1 bits 7..3 and all of control 2 read as 0, and writes to them have no effect.
- R5: With control 1 bit 0 = 1, any set bit of `pm_evt` drives `sci` high, and events alone do not drive `smi`.
- R6: With control 1 bit 0 = 0, an event drives `smi` when `smi_en`=1. When `smi_en`=0, an event drives neither output.
- R7: With control 1 bit 1 = 1, `bm_ctrl_en`=1 and `bm_req`=1, `sci` goes high whatever the state of bit 0.
- R8: Writing 1 to control 1 bit 2 (release strobe) sets `fw_sts` on that write's clock edge. Bit 2 always reads back 0.
- R9: While `fw_sts`=1 and `fw_en`=1, `smi` is high.
- R10: A `fw_sts_clr` pulse clears `fw_sts`. If a release write and a clear happen in the same cycle, the flag ends up set.
- R11: `sci` and `smi` are registered. They reflect their inputs one clock edge later and stay high for as long as the qualifying condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | ADDR_W | Register-pair base address from configuration |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 00h when no hit |
| io_rd_hit | output | 1 | The read targets one of the two registers |
| pm_evt | input | EVT_W | Power-management event levels |
| bm_ctrl_en | input | 1 | Bus-master control enable from the companion register |
| bm_req | input | 1 | Bus-master activity request |
| smi_en | input | 1 | Firmware interrupt enable for routed events |
| fw_en | input | 1 | Firmware enable for the release status flag |
| fw_sts_clr | input | 1 | Write-1-to-clear strobe for the firmware status flag |
| sci | output | 1 | Operating-system interrupt level |
| smi | output | 1 | Firmware interrupt level |
| fw_sts | output | 1 | Firmware status flag set by the release strobe |

## Verification
The assertions assume that `base_addr` holds still while the block runs. They also assume that a write is a single-cycle `io_wr` pulse, so that each release write maps to exactly one clock edge. The stimulus sets the base once before reset is released. It drives every bus strobe for exactly one cycle from the falling edge and changes event and enable levels only between checks, so each expected value has a full cycle to settle.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int CTL1_OFS     = 4;
    localparam int CTL2_OFS     = 5;
    localparam int SCI_EN_BIT   = 0;
    localparam int BM_RLD_BIT   = 1;
    localparam int REL_BIT      = 2;
    localparam logic [7:0] CTL1_WMASK = 8'h03;

    typedef struct packed {
        logic [7:0] ctl1;
    } regs_t;

    typedef struct packed {
        logic fw_sts;
        logic sci;
        logic smi;
    } route_t;
endpackage

// File: rtl/pm_regbank.sv
module pm_regbank
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rd_hit,
    output logic              sci_route,
    output logic              bm_reload,
    output logic              rel_set
);
    logic [ADDR_W-1:0] ctl1_addr;
    logic [ADDR_W-1:0] ctl2_addr;
    logic              hit1;
    logic              hit2;
    regs_t             st_d, st_q;

    assign ctl1_addr = base_addr + ADDR_W'(CTL1_OFS);
    assign ctl2_addr = base_addr + ADDR_W'(CTL2_OFS);
    assign hit1      = (io_addr == ctl1_addr);
    assign hit2      = (io_addr == ctl2_addr);

    always_comb begin
        st_d = st_q;
        if (io_wr && hit1) begin
            st_d.ctl1 = io_wdata & CTL1_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        io_rd_hit = io_rd && (hit1 || hit2);
        io_rdata  = 8'h00;
        if (io_rd && hit1) io_rdata = st_q.ctl1;
    end

    assign sci_route = st_q.ctl1[SCI_EN_BIT];
    assign bm_reload = st_q.ctl1[BM_RLD_BIT];
    assign rel_set   = io_wr && hit1 && io_wdata[REL_BIT];
endmodule

// File: rtl/pm_route.sv
module pm_route
    import pm_evt_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] pm_evt,
    input  logic             sci_route,
    input  logic             bm_reload,
    input  logic             bm_ctrl_en,
    input  logic             bm_req,
    input  logic             smi_en,
    input  logic             fw_en,
    input  logic             rel_set,
    input  logic             fw_sts_clr,
    output logic             sci,
    output logic             smi,
    output logic             fw_sts
);
    route_t st_d, st_q;
    logic   any_evt;

    assign any_evt = |pm_evt;

    always_comb begin
        st_d = st_q;
        if (rel_set)         st_d.fw_sts = 1'b1;
        else if (fw_sts_clr) st_d.fw_sts = 1'b0;
        st_d.sci = (sci_route && any_evt) || (bm_reload && bm_ctrl_en && bm_req);
        st_d.smi = (!sci_route && smi_en && any_evt) || (st_q.fw_sts && fw_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sci    = st_q.sci;
    assign smi    = st_q.smi;
    assign fw_sts = st_q.fw_sts;
endmodule

// File: rtl/pm_evt_router.sv
module pm_evt_router #(
    parameter int ADDR_W = 16,
    parameter int EVT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rd_hit,
    input  logic [EVT_W-1:0]  pm_evt,
    input  logic              bm_ctrl_en,
    input  logic              bm_req,
    input  logic              smi_en,
    input  logic              fw_en,
    input  logic              fw_sts_clr,
    output logic              sci,
    output logic              smi,
    output logic              fw_sts
);
    logic sci_route;
    logic bm_reload;
    logic rel_set;

    pm_regbank #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (base_addr),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .io_rd_hit (io_rd_hit),
        .sci_route (sci_route),
        .bm_reload (bm_reload),
        .rel_set   (rel_set)
    );

    pm_route #(.EVT_W(EVT_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .pm_evt     (pm_evt),
        .sci_route  (sci_route),
        .bm_reload  (bm_reload),
        .bm_ctrl_en (bm_ctrl_en),
        .bm_req     (bm_req),
        .smi_en     (smi_en),
        .fw_en      (fw_en),
        .rel_set    (rel_set),
        .fw_sts_clr (fw_sts_clr),
        .sci        (sci),
        .smi        (smi),
        .fw_sts     (fw_sts)
    );
endmodule

// File: rtl/pm_evt_router_chk.sv
module pm_evt_router_chk #(
    parameter int ADDR_W = 16,
    parameter int EVT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rd_hit,
    input logic [EVT_W-1:0]  pm_evt,
    input logic              bm_ctrl_en,
    input logic              bm_req,
    input logic              smi_en,
    input logic              fw_en,
    input logic              fw_sts_clr,
    input logic              sci,
    input logic              smi,
    input logic              fw_sts,
    input logic              sci_route,
    input logic              bm_reload
);
    logic [ADDR_W-1:0] c1_addr;
    logic              rel_wr;
    assign c1_addr = base_addr + ADDR_W'(4);
    assign rel_wr  = io_wr && (io_addr == c1_addr) && io_wdata[2];

    p_hit_needs_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (!io_rd_hit && io_rdata == 8'h00));
    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[7:3] == 5'b0);
    p_sci_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_route && |pm_evt) |=> sci);
    p_smi_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sci_route && smi_en && |pm_evt) |=> smi);
    p_no_smi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(smi_en && |pm_evt) && !(fw_sts && fw_en)) |=> !smi);
    p_bm_sci_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_reload && bm_ctrl_en && bm_req) |=> sci);
    p_rel_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_wr |=> fw_sts);
    p_fw_smi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_sts && fw_en) |=> smi);
    p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_sts_clr && !rel_wr) |=> !fw_sts);
    p_sts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_sts_clr && !rel_wr) |=> $stable(fw_sts));
endmodule

bind pm_evt_router pm_evt_router_chk #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd_hit(io_rd_hit), .pm_evt(pm_evt), .bm_ctrl_en(bm_ctrl_en),
    .bm_req(bm_req), .smi_en(smi_en), .fw_en(fw_en), .fw_sts_clr(fw_sts_clr),
    .sci(sci), .smi(smi), .fw_sts(fw_sts), .sci_route(sci_route),
    .bm_reload(bm_reload)
);

// File: tb/sim_pm_evt_router.sv
module sim_pm_evt_router;
    localparam int AW = 16;
    localparam int EW = 4;
    localparam logic [AW-1:0] BASE = 16'h0400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic          io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          io_rd_hit;
    logic [EW-1:0] pm_evt = '0;
    logic          bm_ctrl_en = 1'b0, bm_req = 1'b0, smi_en = 1'b0, fw_en = 1'b0, fw_sts_clr = 1'b0;
    logic          sci, smi, fw_sts;

    int total = 0;
    int bad   = 0;

    typedef struct {
        string      tag;
        bit         is_rd;
        logic [7:0] rdata;
        logic       hit;
        logic       sci;
        logic       smi;
        logic       sts;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    pm_evt_router #(.ADDR_W(AW), .EVT_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .base_addr(BASE), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rd_hit(io_rd_hit), .pm_evt(pm_evt), .bm_ctrl_en(bm_ctrl_en),
        .bm_req(bm_req), .smi_en(smi_en), .fw_en(fw_en), .fw_sts_clr(fw_sts_clr),
        .sci(sci), .smi(smi), .fw_sts(fw_sts)
    );

    // monitor: pops each expected item and compares just after it is posted
    initial begin
        forever begin
            item_t it;
            wait (sb.size() > 0);
            #1;
            it = sb.pop_front();
            total++;
            if (it.is_rd) begin
                if (io_rdata !== it.rdata || io_rd_hit !== it.hit) begin
                    bad++;
                    $display("FAIL %s: rdata=%02h hit=%b expected rdata=%02h hit=%b",
                             it.tag, io_rdata, io_rd_hit, it.rdata, it.hit);
                end
            end else if (sci !== it.sci || smi !== it.smi || fw_sts !== it.sts) begin
                bad++;
                $display("FAIL %s: sci=%b smi=%b sts=%b expected sci=%b smi=%b sts=%b",
                         it.tag, sci, smi, fw_sts, it.sci, it.smi, it.sts);
            end
        end
    end

    task automatic post(input item_t it);
        sb.push_back(it);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic exp_out(input string tag, input logic s, input logic m, input logic st);
        item_t it;
        @(negedge clk);
        it = '{tag: tag, is_rd: 1'b0, rdata: 8'h00, hit: 1'b0, sci: s, smi: m, sts: st};
        post(it);
    endtask

    task automatic exp_rd(input string tag, input logic [AW-1:0] a, input logic [7:0] d, input logic h);
        item_t it;
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        it = '{tag: tag, is_rd: 1'b1, rdata: d, hit: h, sci: 1'b0, smi: 1'b0, sts: 1'b0};
        post(it);
        io_rd = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    function automatic logic ref_sci(logic en, logic rld, logic bc, logic br, logic ev);
        return (en && ev) || (rld && bc && br);
    endfunction

    function automatic logic ref_smi(logic en, logic se, logic ev, logic st, logic fe);
        return (!en && se && ev) || (st && fe);
    endfunction

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_out("R1 reset outputs", 1'b0, 1'b0, 1'b0);
        exp_rd("R1 ctl1 reset", BASE + 16'd4, 8'h00, 1'b1);
        exp_rd("R1 ctl2 reset", BASE + 16'd5, 8'h00, 1'b1);
        // R2 decode
        exp_rd("R2 miss base+6", BASE + 16'd6, 8'h00, 1'b0);
        exp_rd("R2 miss base+3", BASE + 16'd3, 8'h00, 1'b0);
        // R3 / R4 write and readback
        wr(BASE + 16'd4, 8'hFB);
        exp_rd("R3 R4 ctl1 masked", BASE + 16'd4, 8'h03, 1'b1);
        wr(BASE + 16'd5, 8'hFF);
        exp_rd("R4 ctl2 ignores write", BASE + 16'd5, 8'h00, 1'b1);
        wr(BASE + 16'd6, 8'h00);
        exp_rd("R2 miss write leaves ctl1", BASE + 16'd4, 8'h03, 1'b1);
        wr(BASE + 16'd4, 8'h02);
        exp_rd("R3 bm reload only", BASE + 16'd4, 8'h02, 1'b1);

        // R5 R6 R7 routing combos
        for (int c = 0; c < 32; c++) begin
            logic en, rld, se, ev, bcr;
            en  = c[0]; rld = c[1]; se = c[2]; ev = c[3]; bcr = c[4];
            wr(BASE + 16'd4, {6'b0, rld, en});
            smi_en     = se;
            pm_evt     = ev ? 4'b0100 : 4'b0000;
            bm_ctrl_en = bcr;
            bm_req     = bcr;
            @(negedge clk);
            exp_out($sformatf("R5 R6 R7 route en=%0b rld=%0b smi_en=%0b evt=%0b bm=%0b", en, rld, se, ev, bcr),
                    ref_sci(en, rld, bcr, bcr, ev), ref_smi(en, se, ev, 1'b0, 1'b0), 1'b0);
        end
        pm_evt = '0; smi_en = 1'b0; bm_ctrl_en = 1'b0; bm_req = 1'b0;
        wr(BASE + 16'd4, 8'h01);
        @(negedge clk);
        exp_out("R11 idle", 1'b0, 1'b0, 1'b0);
        // R11 latency: change then check before and after one edge
        pm_evt = 4'b0001;
        item_t_check_before: begin
            item_t it;
            it = '{tag: "R11 not yet", is_rd: 1'b0, rdata: 8'h00, hit: 1'b0, sci: 1'b0, smi: 1'b0, sts: 1'b0};
            post(it);
        end
        exp_out("R11 one edge later", 1'b1, 1'b0, 1'b0);
        exp_out("R11 level holds", 1'b1, 1'b0, 1'b0);
        pm_evt = '0;
        exp_out("R11 drops", 1'b0, 1'b0, 1'b0);

        // R8 R9 R10 release handshake
        wr(BASE + 16'd4, 8'h04);
        exp_rd("R8 release reads 0", BASE + 16'd4, 8'h00, 1'b1);
        exp_out("R8 status set, fw_en low", 1'b0, 1'b0, 1'b1);
        fw_en = 1'b1;
        exp_out("R9 smi from status", 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        fw_sts_clr = 1'b1;
        @(negedge clk);
        fw_sts_clr = 1'b0;
        exp_out("R10 cleared", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        io_addr = BASE + 16'd4; io_wdata = 8'h04; io_wr = 1'b1; fw_sts_clr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; fw_sts_clr = 1'b0;
        exp_out("R10 set wins over clear", 1'b0, 1'b1, 1'b1);
        fw_en = 1'b0;
        exp_out("R9 fw_en low drops smi", 1'b0, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule